// File: doc/BRIEF.md
# Serial Management Interface Target Frame Engine

This block is the target (slave) end of the two-wire serial management bus. All of its logic runs on the management clock. The shared data line reaches it as three ports: an input, an output and an output enable. The block decodes each frame in order: start pattern, operation code, station address, register number, turnaround and a 16-bit data word. A frame counts only when its station address matches the strapped address. For a matching frame the block pulses a read or write strobe toward an external register file and returns read data on the line.

After reset the block first has to see a run of 32 consecutive one bits before it accepts any frame. Once that has happened it stays synchronized, and later frames may begin straight with the start pattern, with no run of ones in front. Two events drop synchronization: an operation code that is neither read nor write, and a wrong turnaround on a write. After either one, a full 32-bit run of ones is needed again. The block samples the line on the rising edge of the clock and changes its outputs on the rising edge as well.

Top module: `mgmt_serial_target`

## Requirements
- R1: After reset no frame is accepted until 32 consecutive one bits have been sampled while idle. A frame that follows only 31 ones gives no strobe and no drive.
- R2: A frame with start 0,1, operation code 01 (write), a matching station address and turnaround 1,0 pulses reg_we_o for exactly one cycle, the cycle after the 16th data bit is sampled. In that cycle reg_addr_o holds the register number and reg_wdata_o holds the data word. Every field arrives MSB first.
- R3: A frame with operation code 10 (read) and a matching station address pulses reg_re_o for one cycle, the cycle after the last register-number bit. During that cycle mdio_oe_o is low. In the next cycle the block drives 0. After that it drives the 16 bits of reg_rdata_i MSB first, one per cycle, and then releases the line.
- R4: Once synchronized, a frame that begins directly with the start pattern is accepted. This includes a frame whose first start bit is sampled in the same cycle as the previous write's strobe.
- R5: Operation code 00 or 11 drops synchronization. A following frame without a run of ones is ignored, and one preceded by 32 ones is accepted.
- R6: On a write, a turnaround other than 1,0 suppresses the write strobe and drops synchronization.
- R7: A frame whose station address differs from phy_addr_i gives no strobe, and mdio_oe_o stays low for the whole frame.
- R8: While reset is active and right after it, mdio_oe_o, reg_we_o and reg_re_o are low, and reg_addr_o and reg_wdata_o are zero.
- R9: reg_we_o and reg_re_o are never high in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| mdc_i | input | 1 | Management clock; sampling and output changes on its rising edge |
| rst_ni | input | 1 | Asynchronous reset, active low |
| phy_addr_i | input | 5 | Strapped station address |
| mdio_i | input | 1 | Data line as seen at the pad |
| mdio_o | output | 1 | Value to drive onto the data line |
| mdio_oe_o | output | 1 | Drive enable for the data line |
| reg_addr_o | output | 5 | Register number of the current matching frame |
| reg_re_o | output | 1 | One-cycle read strobe |
| reg_rdata_i | input | 16 | Read data returned by the register file |
| reg_we_o | output | 1 | One-cycle write strobe |
| reg_wdata_o | output | 16 | Write data, valid with reg_we_o |

## Verification
Two events can land in the same cycle. One is the write strobe that closes a frame. The other is the sampling of the first start bit of the next frame, sent with no run of ones in between. The bench provokes this by sending a read or a write immediately after a write. A scoreboard checks that the write strobe carries the right register number and data. Separately, the frame that follows is checked for its own strobe, and for reads, for every bit on the line. A missing or stray strobe on either side is reported against R4.

// File: rtl/mgmt_slv_pkg.sv
package mgmt_slv_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_START,
    ST_HDR,
    ST_TA1,
    ST_TA2,
    ST_DATA
  } st_e;

  localparam logic [1:0] OP_WR = 2'b01;
  localparam logic [1:0] OP_RD = 2'b10;
endpackage

// File: rtl/mgmt_pre_sync.sv
module mgmt_pre_sync #(
  parameter int PRE_LEN = 32
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic idle_i,
  input  logic bit_i,
  input  logic lose_i,
  output logic synced_o
);
  localparam int CW = $clog2(PRE_LEN + 1);

  logic [CW-1:0] ones_q;
  logic          synced_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ones_q   <= '0;
      synced_q <= 1'b0;
    end else if (lose_i) begin
      ones_q   <= '0;
      synced_q <= 1'b0;
    end else if (idle_i) begin
      if (bit_i) begin
        if (ones_q != CW'(PRE_LEN)) ones_q <= ones_q + 1'b1;
        if (ones_q == CW'(PRE_LEN - 1)) synced_q <= 1'b1;
      end else begin
        ones_q <= '0;
      end
    end
  end

  assign synced_o = synced_q;

  // R1: synchronization is only gained while idle on a sampled one
  a_r1_sync_on_one: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(synced_q) |-> $past(bit_i) && $past(idle_i));
endmodule

// File: rtl/mgmt_rd_drv.sv
module mgmt_rd_drv #(
  parameter int DW = 16
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          load_i,
  input  logic          shift_i,
  input  logic          stop_i,
  input  logic [DW-1:0] rdata_i,
  output logic          mdio_o,
  output logic          mdio_oe_o
);
  logic [DW-1:0] sr_q;
  logic          oe_q;
  logic          o_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sr_q <= '0;
      oe_q <= 1'b0;
      o_q  <= 1'b0;
    end else if (load_i) begin
      sr_q <= rdata_i;
      oe_q <= 1'b1;
      o_q  <= 1'b0;
    end else if (shift_i) begin
      o_q  <= sr_q[DW-1];
      sr_q <= {sr_q[DW-2:0], 1'b0};
    end else if (stop_i) begin
      oe_q <= 1'b0;
      o_q  <= 1'b0;
    end
  end

  assign mdio_o    = o_q;
  assign mdio_oe_o = oe_q;

  // R3: driving always opens with the turnaround zero
  a_r3_ta_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(oe_q) |-> !o_q);
endmodule

// File: rtl/mgmt_serial_target.sv
module mgmt_serial_target #(
  parameter int AW      = 5,
  parameter int DW      = 16,
  parameter int PRE_LEN = 32
) (
  input  logic          mdc_i,
  input  logic          rst_ni,
  input  logic [AW-1:0] phy_addr_i,
  input  logic          mdio_i,
  output logic          mdio_o,
  output logic          mdio_oe_o,
  output logic [AW-1:0] reg_addr_o,
  output logic          reg_re_o,
  input  logic [DW-1:0] reg_rdata_i,
  output logic          reg_we_o,
  output logic [DW-1:0] reg_wdata_o
);
  import mgmt_slv_pkg::*;

  localparam int HW    = 2 + 2 * AW;
  localparam int CNT_W = $clog2((HW > DW) ? HW : DW);

  st_e             st_q;
  logic [CNT_W-1:0] cnt_q;
  logic [HW-2:0]   hdr_sr_q;
  logic [HW-1:0]   hdr_nxt;
  logic [DW-2:0]   wr_sr_q;
  logic            is_rd_q, hit_q;
  logic            synced, lose, load, shift, stop;
  logic [AW-1:0]   addr_q;
  logic [DW-1:0]   wdata_q;
  logic            we_q, re_q;

  assign hdr_nxt = {hdr_sr_q, mdio_i};

  always_comb begin
    lose = 1'b0;
    if (st_q == ST_HDR && cnt_q == CNT_W'(1) &&
        hdr_nxt[1:0] != OP_WR && hdr_nxt[1:0] != OP_RD) lose = 1'b1;
    if (!is_rd_q && st_q == ST_TA1 && !mdio_i) lose = 1'b1;
    if (!is_rd_q && st_q == ST_TA2 && mdio_i)  lose = 1'b1;
  end

  assign load  = (st_q == ST_TA1) && is_rd_q && hit_q;
  assign shift = is_rd_q && hit_q &&
                 (st_q == ST_TA2 || (st_q == ST_DATA && cnt_q != CNT_W'(DW - 1)));
  assign stop  = (st_q == ST_DATA) && (cnt_q == CNT_W'(DW - 1));

  mgmt_pre_sync #(.PRE_LEN(PRE_LEN)) u_sync (
    .clk_i   (mdc_i),
    .rst_ni  (rst_ni),
    .idle_i  (st_q == ST_IDLE),
    .bit_i   (mdio_i),
    .lose_i  (lose),
    .synced_o(synced)
  );

  mgmt_rd_drv #(.DW(DW)) u_drv (
    .clk_i    (mdc_i),
    .rst_ni   (rst_ni),
    .load_i   (load),
    .shift_i  (shift),
    .stop_i   (stop),
    .rdata_i  (reg_rdata_i),
    .mdio_o   (mdio_o),
    .mdio_oe_o(mdio_oe_o)
  );

  always_ff @(posedge mdc_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q     <= ST_IDLE;
      cnt_q    <= '0;
      hdr_sr_q <= '0;
      wr_sr_q  <= '0;
      is_rd_q  <= 1'b0;
      hit_q    <= 1'b0;
      addr_q   <= '0;
      wdata_q  <= '0;
      we_q     <= 1'b0;
      re_q     <= 1'b0;
    end else begin
      we_q <= 1'b0;
      re_q <= 1'b0;
      unique case (st_q)
        ST_IDLE:  if (!mdio_i && synced) st_q <= ST_START;
        ST_START: begin
          cnt_q <= '0;
          st_q  <= mdio_i ? ST_HDR : ST_IDLE;
        end
        ST_HDR: begin
          hdr_sr_q <= hdr_nxt[HW-2:0];
          cnt_q    <= cnt_q + 1'b1;
          if (lose) begin
            st_q <= ST_IDLE;
          end else if (cnt_q == CNT_W'(HW - 1)) begin
            is_rd_q <= (hdr_nxt[HW-1:HW-2] == OP_RD);
            hit_q   <= (hdr_nxt[2*AW-1:AW] == phy_addr_i);
            if (hdr_nxt[2*AW-1:AW] == phy_addr_i) begin
              addr_q <= hdr_nxt[AW-1:0];
              re_q   <= (hdr_nxt[HW-1:HW-2] == OP_RD);
            end
            st_q <= ST_TA1;
          end
        end
        ST_TA1: st_q <= lose ? ST_IDLE : ST_TA2;
        ST_TA2: begin
          cnt_q <= '0;
          st_q  <= lose ? ST_IDLE : ST_DATA;
        end
        ST_DATA: begin
          wr_sr_q <= {wr_sr_q[DW-3:0], mdio_i};
          cnt_q   <= cnt_q + 1'b1;
          if (cnt_q == CNT_W'(DW - 1)) begin
            st_q <= ST_IDLE;
            if (!is_rd_q && hit_q) begin
              wdata_q <= {wr_sr_q, mdio_i};
              we_q    <= 1'b1;
            end
          end
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  assign reg_addr_o  = addr_q;
  assign reg_wdata_o = wdata_q;
  assign reg_we_o    = we_q;
  assign reg_re_o    = re_q;

  a_r9_strobes_exclusive: assert property (@(posedge mdc_i) disable iff (!rst_ni)
    !(reg_we_o && reg_re_o));
  a_r2_we_single: assert property (@(posedge mdc_i) disable iff (!rst_ni)
    reg_we_o |=> !reg_we_o);
  a_r3_re_single: assert property (@(posedge mdc_i) disable iff (!rst_ni)
    reg_re_o |=> !reg_re_o);
  a_r3_ta_release: assert property (@(posedge mdc_i) disable iff (!rst_ni)
    reg_re_o |-> !mdio_oe_o);
  a_r3_drive_follows: assert property (@(posedge mdc_i) disable iff (!rst_ni)
    reg_re_o |=> mdio_oe_o);
  a_r7_drive_needs_sync: assert property (@(posedge mdc_i) disable iff (!rst_ni)
    mdio_oe_o |-> synced);
endmodule

// File: tb/mgmt_serial_target_bench.sv
module mgmt_serial_target_bench;
  localparam logic [4:0] PHY = 5'h0C;

  typedef struct packed {
    logic        wr;
    logic [4:0]  a;
    logic [15:0] d;
  } item_t;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        mdio_drv = 1'b0;
  logic        mdio_o, mdio_oe;
  logic [4:0]  reg_addr;
  logic        reg_re, reg_we;
  logic [15:0] reg_rdata, reg_wdata;
  int          checks = 0;
  int          failures = 0;
  bit          done = 1'b0;
  item_t       exp_q[$];

  always #4 clk = ~clk;

  function automatic logic [15:0] rd_model(input logic [4:0] a);
    return {a, ~a, a, 1'b1};
  endfunction

  assign reg_rdata = rd_model(reg_addr);

  mgmt_serial_target u_mgmt_serial_target (
    .mdc_i(clk), .rst_ni(rst_n), .phy_addr_i(PHY),
    .mdio_i(mdio_drv), .mdio_o(mdio_o), .mdio_oe_o(mdio_oe),
    .reg_addr_o(reg_addr), .reg_re_o(reg_re), .reg_rdata_i(reg_rdata),
    .reg_we_o(reg_we), .reg_wdata_o(reg_wdata)
  );

  task automatic check(input bit ok, input string msg, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s act=%0h exp=%0h", msg, act, exp);
    end
  endtask

  // monitor: every strobe must match the head of the scoreboard
  always @(negedge clk) begin
    if (rst_n && (reg_we || reg_re)) begin
      if (exp_q.size() == 0) begin
        check(1'b0, "R1 R5 R6 R7 unexpected strobe", {reg_we, reg_re, reg_addr}, 0);
      end else begin
        item_t e;
        e = exp_q.pop_front();
        check(reg_we == e.wr && reg_re == !e.wr, "R2 R3 R4 strobe kind", {reg_we, reg_re}, {e.wr, !e.wr});
        check(reg_addr == e.a, "R2 R3 register number", reg_addr, e.a);
        if (e.wr) check(reg_wdata == e.d, "R2 write data", reg_wdata, e.d);
      end
    end
  end

  task automatic send(input logic b);
    @(negedge clk);
    mdio_drv = b;
  endtask

  task automatic preamble(input int n);
    for (int i = 0; i < n; i++) send(1'b1);
  endtask

  task automatic hdr(input logic [1:0] op, input logic [4:0] phy, input logic [4:0] ra);
    send(1'b0); send(1'b1);
    for (int i = 1; i >= 0; i--) send(op[i]);
    for (int i = 4; i >= 0; i--) send(phy[i]);
    for (int i = 4; i >= 0; i--) send(ra[i]);
  endtask

  task automatic raw_frame(input logic [1:0] op, input logic [4:0] phy, input logic [4:0] ra,
                           input logic [1:0] ta, input logic [15:0] d, input bit expect_wr);
    if (expect_wr) exp_q.push_back('{wr: 1'b1, a: ra, d: d});
    hdr(op, phy, ra);
    send(ta[1]); send(ta[0]);
    for (int i = 15; i >= 0; i--) send(d[i]);
  endtask

  task automatic rd_frame(input logic [4:0] phy, input logic [4:0] ra, input bit expect_drv);
    logic [15:0] d;
    d = rd_model(ra);
    if (expect_drv) exp_q.push_back('{wr: 1'b0, a: ra, d: d});
    hdr(2'b10, phy, ra);
    for (int k = 0; k < 18; k++) begin
      @(negedge clk);
      mdio_drv = 1'b1;
      if (!expect_drv) check(mdio_oe == 1'b0, "R7 no drive for other station", mdio_oe, 0);
      else if (k == 0) check(mdio_oe == 1'b0, "R3 first turnaround released", mdio_oe, 0);
      else if (k == 1) check(mdio_oe && !mdio_o, "R3 second turnaround zero", {mdio_oe, mdio_o}, 2'b10);
      else check(mdio_oe && mdio_o == d[17-k], "R3 read data bit", {mdio_oe, mdio_o}, {1'b1, d[17-k]});
    end
    @(negedge clk);
    mdio_drv = 1'b1;
    check(mdio_oe == 1'b0, "R3 line released after data", mdio_oe, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check(!mdio_oe && !reg_we && !reg_re, "R8 strobes and enable low in reset", {mdio_oe, reg_we, reg_re}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    check(reg_addr == 0 && reg_wdata == 0, "R8 outputs zero after reset", {reg_addr, reg_wdata}, 0);

    // R1: 31 ones are not enough
    preamble(31);
    raw_frame(2'b01, PHY, 5'd3, 2'b10, 16'hA5C3, 1'b0);
    preamble(32);
    raw_frame(2'b01, PHY, 5'd3, 2'b10, 16'hA5C3, 1'b1);   // R2
    // R4: back-to-back frames without a run of ones
    raw_frame(2'b01, PHY, 5'd5, 2'b10, 16'h0001, 1'b1);
    rd_frame(PHY, 5'd5, 1'b1);
    rd_frame(PHY, 5'd31, 1'b1);
    raw_frame(2'b01, PHY, 5'd0, 2'b10, 16'hFFFF, 1'b1);
    raw_frame(2'b01, PHY, 5'd31, 2'b10, 16'h8000, 1'b1);
    // R7: other station address
    raw_frame(2'b01, PHY ^ 5'h01, 5'd2, 2'b10, 16'h1234, 1'b0);
    rd_frame(PHY ^ 5'h10, 5'd9, 1'b0);
    raw_frame(2'b01, PHY, 5'd7, 2'b10, 16'h5AA5, 1'b1);
    // R5: invalid opcodes
    raw_frame(2'b11, PHY, 5'd1, 2'b10, 16'h1234, 1'b0);
    raw_frame(2'b01, PHY, 5'd1, 2'b10, 16'h0F00, 1'b0);
    preamble(32);
    raw_frame(2'b01, PHY, 5'd1, 2'b10, 16'h0F00, 1'b1);
    raw_frame(2'b00, PHY, 5'd1, 2'b10, 16'h0000, 1'b0);
    rd_frame(PHY, 5'd4, 1'b0);
    preamble(32);
    rd_frame(PHY, 5'd4, 1'b1);
    // R6: bad turnaround on writes
    raw_frame(2'b01, PHY, 5'd6, 2'b11, 16'h2222, 1'b0);
    raw_frame(2'b01, PHY, 5'd6, 2'b10, 16'h2222, 1'b0);
    preamble(32);
    raw_frame(2'b01, PHY, 5'd6, 2'b00, 16'h3333, 1'b0);
    preamble(32);
    raw_frame(2'b01, PHY, 5'd6, 2'b10, 16'h4444, 1'b1);

    preamble(4);
    check(exp_q.size() == 0, "R2 R3 expected strobes all seen", exp_q.size(), 0);
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog expired R1 act=0 exp=1");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule